// File: doc/BRIEF.md
# USB Device Control Register

This block holds the main control and status byte of a USB device serial interface engine, together with the even/odd buffer-bank pointers of every endpoint direction. Firmware writes and reads the byte over a simple register bus. The byte has a write strobe and write data, and its read data is always valid. The block drives the engine's enable, clock-enable, resume and processing-block controls from the stored bits. When the engine reports a SETUP token, the block stops further token processing until firmware clears that condition.

Each endpoint direction has one pointer bit. That bit selects the even bank (0) or the odd bank (1) of its buffer descriptor pair. It flips each time the engine reports a finished transfer on that direction. Two events return every pointer to the even bank: a dedicated reset bit, and turning the module on. The live single-ended-zero state of the bus passes through a two-flop synchronizer and can be read as a status bit.

Top module: `usb_ctrl_reg`

## Requirements
- R1: Register byte layout: bit 6 = bank-pointer reset (rw), bit 5 = single-ended-zero flag (read-only), bit 4 = processing block (clear-only), bit 3 = module enable (rw), bit 2 = resume (rw), bit 1 = suspend (rw). Bits 7 and 0 always read 0, and the rw bits read back the last value written.
- R2: After reset, every stored bit, every bank pointer and every control output is 0.
- R3: A cycle with setup_rx_i high sets the processing-block bit at the next edge. A write with bit 4 = 0 clears it, and a write with bit 4 = 1 leaves it unchanged.
- R4: If setup_rx_i and a write that clears bit 4 occur in the same cycle, the bit ends up 1.
- R5: The single-ended-zero flag reads 1 exactly when both line_dp_i and line_dm_i were low two clock edges earlier.
- R6: While the bank-pointer reset bit is 1, ppb_o is all zero, completion strobes have no effect, and after the bit is cleared every pointer starts from 0.
- R7: A write that takes the module enable bit from 0 to 1 clears every bank pointer at that edge.
- R8: While the module is enabled and no pointer reset is active, ppb_o[2*ep+dir] toggles at the edge after a cycle in which xfer_done_i[2*ep+dir] is high. Here dir 0 = OUT and dir 1 = IN.
- R9: While the module enable bit is 0, resume_o, pkt_block_o and sie_clk_en_o are 0, and completion strobes do not change any pointer.
- R10: mod_en_o follows the enable bit, sie_clk_en_o is enable AND NOT suspend, resume_o is enable AND resume, and pkt_block_o is enable AND processing block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| setup_rx_i | input | 1 | SETUP token received strobe from the engine |
| line_dp_i | input | 1 | D+ line state (asynchronous) |
| line_dm_i | input | 1 | D- line state (asynchronous) |
| xfer_done_i | input | 2*NUM_EP | Per endpoint-direction transfer completion strobes |
| ppb_o | output | 2*NUM_EP | Per endpoint-direction bank pointer (0 = even) |
| mod_en_o | output | 1 | Module enable |
| sie_clk_en_o | output | 1 | Engine clock enable |
| resume_o | output | 1 | Resume signaling request |
| pkt_block_o | output | 1 | Token and packet processing block |

## Verification
The assertions check on every cycle that a SETUP strobe sets the processing-block bit, and that this set wins over a simultaneous clear. They also check that the synchronized flag tracks the line state two edges late, that the pointer reset bit and an enable rise zero the pointers, and that the pointers toggle exactly on their strobes. Finally they check that all controls are quiet while the module is off. The behaviours that depend on history come only from the bench's scenarios. These are the readback of all 256 write values combined with SETUP strobes, the ignored strobes while disabled, and the pointer values that follow multi-step sequences of enable, disable and reset.

// File: rtl/usb_ctrl_pkg.sv
package usb_ctrl_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned BIT_PPRST = 6;
  localparam int unsigned BIT_SE0   = 5;
  localparam int unsigned BIT_BLOCK = 4;
  localparam int unsigned BIT_EN    = 3;
  localparam int unsigned BIT_RSM   = 2;
  localparam int unsigned BIT_SUSP  = 1;

  typedef struct packed {
    logic pp_rst;
    logic block;
    logic en;
    logic rsm;
    logic susp;
  } ctrl_bits_t;
endpackage

// File: rtl/usb_ctrl_sync.sv
module usb_ctrl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/usb_ctrl_csr.sv
module usb_ctrl_csr
  import usb_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             setup_i,
  input  logic             se0_i,
  output ctrl_bits_t       bits_o,
  output logic             en_rise_o,
  output logic [REG_W-1:0] rdata_o
);
  ctrl_bits_t bits_q, bits_d;

  always_comb begin
    bits_d = bits_q;
    if (we_i) begin
      bits_d.pp_rst = wdata_i[BIT_PPRST];
      bits_d.en     = wdata_i[BIT_EN];
      bits_d.rsm    = wdata_i[BIT_RSM];
      bits_d.susp   = wdata_i[BIT_SUSP];
      if (!wdata_i[BIT_BLOCK]) bits_d.block = 1'b0;
    end
    // hardware set has priority over software clear
    if (setup_i) bits_d.block = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else         bits_q <= bits_d;
  end

  assign en_rise_o = we_i & wdata_i[BIT_EN] & ~bits_q.en;
  assign bits_o    = bits_q;

  always_comb begin
    rdata_o            = '0;
    rdata_o[BIT_PPRST] = bits_q.pp_rst;
    rdata_o[BIT_SE0]   = se0_i;
    rdata_o[BIT_BLOCK] = bits_q.block;
    rdata_o[BIT_EN]    = bits_q.en;
    rdata_o[BIT_RSM]   = bits_q.rsm;
    rdata_o[BIT_SUSP]  = bits_q.susp;
  end
endmodule

// File: rtl/usb_ctrl_ppb.sv
module usb_ctrl_ppb #(
  parameter int unsigned NUM_PTR = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               force_even_i,
  input  logic               tog_en_i,
  input  logic [NUM_PTR-1:0] done_i,
  output logic [NUM_PTR-1:0] ppb_o
);
  logic [NUM_PTR-1:0] ptr_q;

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      ptr_q[i] <= 1'b0;
      else if (clr_i)                   ptr_q[i] <= 1'b0;
      else if (tog_en_i && done_i[i])   ptr_q[i] <= ~ptr_q[i];
    end
    assign ppb_o[i] = ptr_q[i] & ~force_even_i;
  end
endmodule

// File: rtl/usb_ctrl_reg.sv
module usb_ctrl_reg
  import usb_ctrl_pkg::*;
#(
  parameter int unsigned NUM_EP = 16,
  localparam int unsigned NUM_PTR = 2 * NUM_EP
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic               setup_rx_i,
  input  logic               line_dp_i,
  input  logic               line_dm_i,
  input  logic [NUM_PTR-1:0] xfer_done_i,
  output logic [NUM_PTR-1:0] ppb_o,
  output logic               mod_en_o,
  output logic               sie_clk_en_o,
  output logic               resume_o,
  output logic               pkt_block_o
);
  ctrl_bits_t bits;
  logic       en_rise;
  logic       se0_sync;

  usb_ctrl_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (~line_dp_i & ~line_dm_i),
    .q_o   (se0_sync)
  );

  usb_ctrl_csr u_csr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .setup_i  (setup_rx_i),
    .se0_i    (se0_sync),
    .bits_o   (bits),
    .en_rise_o(en_rise),
    .rdata_o  (reg_rdata_o)
  );

  usb_ctrl_ppb #(.NUM_PTR(NUM_PTR)) u_ppb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (bits.pp_rst | en_rise),
    .force_even_i(bits.pp_rst),
    .tog_en_i    (bits.en),
    .done_i      (xfer_done_i),
    .ppb_o       (ppb_o)
  );

  assign mod_en_o     = bits.en;
  assign sie_clk_en_o = bits.en & ~bits.susp;
  assign resume_o     = bits.en & bits.rsm;
  assign pkt_block_o  = bits.en & bits.block;
endmodule

// File: rtl/usb_ctrl_chk.sv
module usb_ctrl_chk #(
  parameter int unsigned NUM_PTR = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [7:0]         reg_wdata_i,
  input logic [7:0]         reg_rdata_o,
  input logic               setup_rx_i,
  input logic               line_dp_i,
  input logic               line_dm_i,
  input logic [NUM_PTR-1:0] xfer_done_i,
  input logic [NUM_PTR-1:0] ppb_o,
  input logic               mod_en_o,
  input logic               sie_clk_en_o,
  input logic               resume_o,
  input logic               pkt_block_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_setup_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_rx_i |=> reg_rdata_o[4]);

  assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_rx_i && reg_we_i && !reg_wdata_i[4]) |=> reg_rdata_o[4]);

  assert_se0_sync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (reg_rdata_o[5] == $past(!line_dp_i && !line_dm_i, 2)));

  assert_force_even_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[6] |-> (ppb_o == '0));

  assert_en_rise_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_wdata_i[3] && !reg_rdata_o[3] && !reg_wdata_i[6]) |=> (ppb_o == '0));

  assert_toggle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_en_o && !reg_rdata_o[6] && !(reg_we_i && reg_wdata_i[6]))
      |=> (ppb_o == $past(ppb_o ^ xfer_done_i)));

  assert_off_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mod_en_o |-> (!resume_o && !pkt_block_o && !sie_clk_en_o));

  assert_off_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mod_en_o && !reg_rdata_o[6] && !reg_we_i) |=> $stable(ppb_o));

  assert_en_mirror_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_en_o == reg_rdata_o[3]);
endmodule

bind usb_ctrl_reg usb_ctrl_chk #(.NUM_PTR(NUM_PTR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .setup_rx_i  (setup_rx_i),
  .line_dp_i   (line_dp_i),
  .line_dm_i   (line_dm_i),
  .xfer_done_i (xfer_done_i),
  .ppb_o       (ppb_o),
  .mod_en_o    (mod_en_o),
  .sie_clk_en_o(sie_clk_en_o),
  .resume_o    (resume_o),
  .pkt_block_o (pkt_block_o)
);

// File: tb/sim_usb_ctrl_reg.sv
module sim_usb_ctrl_reg;
  localparam int unsigned NUM_EP = 16;
  localparam int unsigned NP = 2 * NUM_EP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic setup = 1'b0;
  logic dp = 1'b1, dm = 1'b0;
  logic [NP-1:0] done = '0;
  logic [NP-1:0] ppb;
  logic en_o, clk_en_o, rsm_o, blk_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [NP-1:0] ptr_m;
  logic pk_m;

  always #5 clk = ~clk;

  usb_ctrl_reg #(.NUM_EP(NUM_EP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .setup_rx_i(setup), .line_dp_i(dp), .line_dm_i(dm),
    .xfer_done_i(done), .ppb_o(ppb), .mod_en_o(en_o), .sie_clk_en_o(clk_en_o),
    .resume_o(rsm_o), .pkt_block_o(blk_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v, input logic stp);
    @(negedge clk);
    we = 1'b1; wdata = v; setup = stp;
    @(negedge clk);
    we = 1'b0; setup = 1'b0;
  endtask

  task automatic pulse_done(input logic [NP-1:0] p);
    @(negedge clk);
    done = p;
    @(negedge clk);
    done = '0;
  endtask

  task automatic pulse_setup();
    @(negedge clk);
    setup = 1'b1;
    @(negedge clk);
    setup = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2 rdata", rdata, 8'h00);
    check("R2 ppb", ppb, '0);
    check("R2 ctrl", {en_o, clk_en_o, rsm_o, blk_o}, 4'b0000);

    // R1 R3 R4 R10 sweep of all write values; bit0 of value also drives setup
    pk_m = 1'b0;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      logic [7:0] exp;
      b = v[7:0];
      wr(b, b[0]);
      pk_m = b[0] ? 1'b1 : (b[4] ? pk_m : 1'b0);
      exp = {1'b0, b[6], 1'b0, pk_m, b[3], b[2], b[1], 1'b0};
      check("R1 readback", rdata, exp);
      check("R10 ctrl", {en_o, clk_en_o, rsm_o, blk_o},
            {b[3], b[3] & ~b[1], b[3] & b[2], b[3] & pk_m});
    end

    // R3 clear-only behaviour
    wr(8'h08, 1'b0);
    check("R3 cleared", rdata[4], 1'b0);
    wr(8'h18, 1'b0);
    check("R3 write1 no set", rdata[4], 1'b0);
    pulse_setup();
    check("R3 setup set", rdata[4], 1'b1);
    check("R10 block out", blk_o, 1'b1);
    wr(8'h18, 1'b0);
    check("R3 write1 keeps", rdata[4], 1'b1);
    wr(8'h08, 1'b1);
    check("R4 set wins", rdata[4], 1'b1);
    wr(8'h08, 1'b0);
    check("R3 clear", rdata[4], 1'b0);

    // R5 synchronizer latency
    @(negedge clk); dp = 1'b0; dm = 1'b0;
    @(negedge clk);
    check("R5 one edge", rdata[5], 1'b0);
    @(negedge clk);
    check("R5 two edges", rdata[5], 1'b1);
    dm = 1'b1;
    @(negedge clk);
    check("R5 hold", rdata[5], 1'b1);
    @(negedge clk);
    check("R5 drop", rdata[5], 1'b0);
    dp = 1'b1; dm = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 j state", rdata[5], 1'b0);

    // R8 toggles per endpoint direction, enabled
    ptr_m = '0;
    for (int k = 0; k < NP; k++) begin
      logic [NP-1:0] p;
      p = (NP'(1) << k) | (NP'(k * 32'h9E37_79B9));
      pulse_done(p);
      ptr_m = ptr_m ^ p;
      check("R8 toggle", ppb, ptr_m);
    end
    check("R8 nonzero", (ppb != '0), 1'b1);

    // R6 force even while reset bit set
    wr(8'h48, 1'b0);
    check("R6 forced", ppb, '0);
    pulse_done('1);
    check("R6 strobes ignored", ppb, '0);
    wr(8'h08, 1'b0);
    check("R6 restart even", ppb, '0);
    pulse_done(NP'(32'h0000_00A5));
    check("R8 after reset", ppb, NP'(32'h0000_00A5));

    // R9 disabled: strobes ignored, outputs quiet
    wr(8'h16, 1'b1);
    check("R9 ctrl off", {en_o, clk_en_o, rsm_o, blk_o}, 4'b0000);
    pulse_done('1);
    check("R9 ptr hold", ppb, NP'(32'h0000_00A5));

    // R7 enable rise clears, even with strobe in same cycle
    @(negedge clk);
    we = 1'b1; wdata = 8'h08; done = '1;
    @(negedge clk);
    we = 1'b0; done = '0;
    check("R7 rise clear", ppb, '0);
    check("R10 clk en", clk_en_o, 1'b1);
    pulse_done(NP'(32'h8000_0001));
    wr(8'h08, 1'b0);
    check("R7 no rise keeps", ppb, NP'(32'h8000_0001));
    wr(8'h0A, 1'b0);
    check("R10 suspend", clk_en_o, 1'b0);

    summary();
  end
endmodule